// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block decides when a bank-organised DRAM array is refreshed and what the processor side sees while that happens. An interval timer, counting input clock cycles from a programmable reload value, raises refresh requests. Requests that have not yet been serviced wait in a small saturating counter. A row counter and a bank pointer give the address of each refresh. A refresh cycle drives only the row strobe, for a fixed number of clocks, and never a column strobe.

Four mode bits shape the service. Slow mode stretches the request interval by four. Burst mode turns each request into four refresh cycles back to back. Staggered mode refreshes one bank at a time, in turn, instead of all banks together. Hidden mode waits for a falling edge of the processor's address latch strobe before it starts a refresh, and never stalls the processor. Outside hidden mode, the processor is held off by a stretch signal for exactly the span of each refresh. The mode bits are taken in only while the scheduler is idle.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, ref_ras, cpu_stall, ref_bank_sel and ref_row are all zero.
- R2: With every mode bit clear, the timer raises one request every cfg_reload clock cycles (cfg_reload >= 1). Each request starts a refresh on the clock after it is raised when the scheduler is idle.
- R3: With cfg_slow set, the request interval is 4*cfg_reload clock cycles.
- R4: Each refresh cycle holds ref_ras high for RAS_CYC clocks, and ref_bank_sel is nonzero exactly while ref_ras is high.
- R5: ref_row advances by one, modulo 2^ROW_W, after each completed refresh of all banks, and it wraps from 255 to 0.
- R6: With cfg_burst set, one request yields BURST_LEN (4) refresh cycles back to back, with ref_ras held high for 4*RAS_CYC clocks.
- R7: With cfg_stagger set, ref_bank_sel is one-hot, with bit i selecting bank i. Banks are visited in the order 0,1,...,BANKS-1, and ref_row advances only after bank BANKS-1.
- R8: With cfg_stagger clear, ref_bank_sel is all ones during a refresh.
- R9: With cfg_hidden set, a refresh starts (ref_ras rises) on the clock after the clock where ale is seen low having been high on the previous clock. cpu_stall stays low.
- R10: With cfg_hidden clear, cpu_stall equals ref_ras on every cycle.
- R11: Unserviced requests are counted up to 7. Further requests at 7 are dropped, and each counted request is later serviced.
- R12: Mode bits are taken in only on idle cycles that do not start a refresh. A change during a refresh, burst or stagger step has no effect until the scheduler is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_reload | input | RELOAD_W | Request interval in clock cycles (normal mode) |
| cfg_slow | input | 1 | Stretch the interval by four |
| cfg_burst | input | 1 | Four refresh cycles per request |
| cfg_stagger | input | 1 | Refresh one bank at a time |
| cfg_hidden | input | 1 | Align refresh to falling edge of ale, no stall |
| ale | input | 1 | Processor address latch strobe |
| ref_row | output | ROW_W | Row address being refreshed |
| ref_bank_sel | output | BANKS | Bank select, one bit per bank |
| ref_ras | output | 1 | Row strobe for a row-only refresh |
| cpu_stall | output | 1 | Holds off the processor cycle during a refresh |

## Verification
The assertions assume cfg_reload is at least 1, so that the timer wraps. They also assume ale and the cfg inputs change only between clock edges. The bench drives every input on the falling clock edge and draws reload values from 3 upward. It changes mode bits freely, including in the middle of refreshes, because the scheduler must ignore such changes until it is idle. The hidden-mode phases first hold ale low so that requests pile up to the saturation limit. They then toggle ale so the backlog drains.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
  typedef struct packed {
    logic slow;
    logic burst;
    logic stagger;
    logic hidden;
  } rs_mode_t;
endpackage

// File: rtl/rs_interval_timer.sv
module rs_interval_timer #(
  parameter int RELOAD_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                slow,
  output logic                tick
);
  localparam int TW = RELOAD_W + 2;
  logic [TW-1:0] cnt;
  logic [TW-1:0] limit;

  assign limit = slow ? {reload, 2'b00} : {2'b00, reload};
  assign tick  = (cnt >= limit - TW'(1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/rs_pending_ctr.sv
module rs_pending_ctr #(
  parameter int PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              add,
  input  logic              take,
  output logic [PEND_W-1:0] pending,
  output logic              any
);
  localparam logic [PEND_W-1:0] FULL = '1;

  assign any = (pending != '0);

  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else if (add && !take && pending != FULL) pending <= pending + PEND_W'(1);
    else if (!add && take) pending <= pending - PEND_W'(1);
  end
endmodule

// File: rtl/rs_addr_gen.sv
module rs_addr_gen #(
  parameter int ROW_W = 8,
  parameter int BANKS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  input  logic                     stagger,
  output logic [ROW_W-1:0]         row,
  output logic [$clog2(BANKS)-1:0] bank,
  output logic [$clog2(BANKS)-1:0] bank_nxt
);
  localparam int BANK_W = $clog2(BANKS);
  localparam logic [BANK_W-1:0] LAST = BANK_W'(BANKS - 1);
  logic wrap;

  assign wrap     = !stagger || (bank == LAST);
  assign bank_nxt = !stagger ? bank : (bank == LAST ? '0 : bank + BANK_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      row  <= '0;
      bank <= '0;
    end else if (step) begin
      bank <= bank_nxt;
      if (wrap) row <= row + ROW_W'(1);
    end
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int ROW_W     = 8,
  parameter int BANKS     = 4,
  parameter int RELOAD_W  = 12,
  parameter int RAS_CYC   = 3,
  parameter int BURST_LEN = 4,
  parameter int PEND_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [RELOAD_W-1:0] cfg_reload,
  input  logic                cfg_slow,
  input  logic                cfg_burst,
  input  logic                cfg_stagger,
  input  logic                cfg_hidden,
  input  logic                ale,
  output logic [ROW_W-1:0]    ref_row,
  output logic [BANKS-1:0]    ref_bank_sel,
  output logic                ref_ras,
  output logic                cpu_stall
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int DUR_W  = $clog2(RAS_CYC + 1);
  localparam int LEFT_W = $clog2(BURST_LEN + 1);

  rs_mode_t           mode_q;
  rs_mode_t           cfg;
  logic               busy;
  logic [DUR_W-1:0]   dur;
  logic [LEFT_W-1:0]  left;
  logic               ale_q;
  logic               tick, any, start, last, step;
  logic [PEND_W-1:0]  pending;
  logic [BANK_W-1:0]  bank, bank_nxt;
  logic [BANKS-1:0]   sel_now, sel_nxt;
  logic [BANKS-1:0]   bsel_q;
  logic               ras_q, stall_q;

  assign cfg   = '{slow: cfg_slow, burst: cfg_burst, stagger: cfg_stagger, hidden: cfg_hidden};
  assign start = !busy && any && (mode_q.hidden ? (ale_q && !ale) : 1'b1);
  assign last  = (dur == DUR_W'(RAS_CYC - 1));
  assign step  = busy && last;

  assign sel_now = mode_q.stagger ? (BANKS'(1) << bank)     : '1;
  assign sel_nxt = mode_q.stagger ? (BANKS'(1) << bank_nxt) : '1;

  rs_interval_timer #(.RELOAD_W(RELOAD_W)) u_timer (
    .clk(clk), .rst(rst), .reload(cfg_reload), .slow(mode_q.slow), .tick(tick)
  );

  rs_pending_ctr #(.PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst(rst), .add(tick), .take(start), .pending(pending), .any(any)
  );

  rs_addr_gen #(.ROW_W(ROW_W), .BANKS(BANKS)) u_addr (
    .clk(clk), .rst(rst), .step(step), .stagger(mode_q.stagger),
    .row(ref_row), .bank(bank), .bank_nxt(bank_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      dur     <= '0;
      left    <= '0;
      mode_q  <= '0;
      ale_q   <= 1'b0;
      ras_q   <= 1'b0;
      stall_q <= 1'b0;
      bsel_q  <= '0;
    end else begin
      ale_q <= ale;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          dur     <= '0;
          left    <= mode_q.burst ? LEFT_W'(BURST_LEN - 1) : '0;
          ras_q   <= 1'b1;
          stall_q <= !mode_q.hidden;
          bsel_q  <= sel_now;
        end else begin
          mode_q <= cfg;
        end
      end else if (last) begin
        if (left != '0) begin
          left   <= left - LEFT_W'(1);
          dur    <= '0;
          bsel_q <= sel_nxt;
        end else begin
          busy    <= 1'b0;
          ras_q   <= 1'b0;
          stall_q <= 1'b0;
          bsel_q  <= '0;
        end
      end else begin
        dur <= dur + DUR_W'(1);
      end
    end
  end

  assign ref_ras      = ras_q;
  assign cpu_stall    = stall_q;
  assign ref_bank_sel = bsel_q;
endmodule

module refresh_sched_chk #(
  parameter int ROW_W  = 8,
  parameter int BANKS  = 4,
  parameter int PEND_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ras,
  input logic              stall,
  input logic [BANKS-1:0]  bsel,
  input logic [ROW_W-1:0]  row,
  input logic              hid_q,
  input logic              stag_q,
  input logic [PEND_W-1:0] pend,
  input logic              tick,
  input logic              take
);
  // R4: bank select accompanies the row strobe
  p_bank_with_ras_r4: assert property (@(posedge clk) disable iff (rst)
    ras == (bsel != '0));
  // R7: staggered refresh touches one bank
  p_stagger_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    (ras && stag_q) |-> $onehot(bsel));
  // R8: all banks together otherwise
  p_all_banks_r8: assert property (@(posedge clk) disable iff (rst)
    (ras && !stag_q) |-> (bsel == '1));
  // R9: hidden refresh never stalls
  p_hidden_nostall_r9: assert property (@(posedge clk) disable iff (rst)
    hid_q |-> !stall);
  // R10: stretch spans the refresh exactly
  p_stall_match_r10: assert property (@(posedge clk) disable iff (rst)
    !hid_q |-> (stall == ras));
  // R5: row only holds or steps by one
  p_row_step_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (row == $past(row)) || (row == ROW_W'($past(row) + 1'b1)));
  // R11: saturated backlog stays saturated
  p_pend_sat_r11: assert property (@(posedge clk) disable iff (rst)
    (pend == '1 && tick && !take) |=> (pend == '1));
endmodule

bind refresh_sched refresh_sched_chk #(.ROW_W(ROW_W), .BANKS(BANKS), .PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst(rst), .ras(ref_ras), .stall(cpu_stall), .bsel(ref_bank_sel),
  .row(ref_row), .hid_q(mode_q.hidden), .stag_q(mode_q.stagger),
  .pend(pending), .tick(tick), .take(start)
);

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 8, BANKS = 4, RELOAD_W = 12, RAS_CYC = 3, BURST_LEN = 4;
  localparam int ALLB = (1 << BANKS) - 1;

  logic clk = 0, rst = 1;
  logic [RELOAD_W-1:0] cfg_reload = 12'd20;
  logic cfg_slow = 0, cfg_burst = 0, cfg_stagger = 0, cfg_hidden = 0, ale = 0;
  logic [ROW_W-1:0] ref_row;
  logic [BANKS-1:0] ref_bank_sel;
  logic ref_ras, cpu_stall;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit checking = 0;
  string tag = "R1";

  // reference model state
  int m_timer, m_pend, m_busy, m_dur, m_left, m_row, m_bank, m_aleq;
  int m_slow, m_burst, m_stag, m_hid, m_ras, m_stall, m_bsel;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_sched #(.ROW_W(ROW_W), .BANKS(BANKS), .RELOAD_W(RELOAD_W),
                  .RAS_CYC(RAS_CYC), .BURST_LEN(BURST_LEN)) u_refresh_sched (
    .clk(clk), .rst(rst), .cfg_reload(cfg_reload), .cfg_slow(cfg_slow),
    .cfg_burst(cfg_burst), .cfg_stagger(cfg_stagger), .cfg_hidden(cfg_hidden),
    .ale(ale), .ref_row(ref_row), .ref_bank_sel(ref_bank_sel),
    .ref_ras(ref_ras), .cpu_stall(cpu_stall));

  always @(posedge clk) begin
    int period, tk, st;
    if (rst) begin
      m_timer = 0; m_pend = 0; m_busy = 0; m_dur = 0; m_left = 0; m_row = 0;
      m_bank = 0; m_aleq = 0; m_slow = 0; m_burst = 0; m_stag = 0; m_hid = 0;
      m_ras = 0; m_stall = 0; m_bsel = 0;
    end else begin
      period = m_slow ? 4 * int'(cfg_reload) : int'(cfg_reload);
      tk = (m_timer >= period - 1);
      st = (!m_busy && m_pend > 0 && (m_hid ? (m_aleq && !ale) : 1));
      m_timer = tk ? 0 : m_timer + 1;
      m_pend = m_pend + tk - st;
      if (m_pend > 7) m_pend = 7;
      if (!m_busy) begin
        if (st) begin
          m_busy = 1; m_dur = 0; m_left = m_burst ? BURST_LEN - 1 : 0;
          m_ras = 1; m_stall = !m_hid; m_bsel = m_stag ? (1 << m_bank) : ALLB;
        end else begin
          m_slow = cfg_slow; m_burst = cfg_burst; m_stag = cfg_stagger; m_hid = cfg_hidden;
        end
      end else if (m_dur == RAS_CYC - 1) begin
        if (m_stag) begin
          if (m_bank == BANKS - 1) begin m_bank = 0; m_row = (m_row + 1) % 256; end
          else m_bank = m_bank + 1;
        end else m_row = (m_row + 1) % 256;
        if (m_left > 0) begin
          m_left--; m_dur = 0; m_bsel = m_stag ? (1 << m_bank) : ALLB;
        end else begin
          m_busy = 0; m_ras = 0; m_stall = 0; m_bsel = 0;
        end
      end else m_dur++;
      m_aleq = ale;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      vectors++;
      if (ref_ras !== 1'(m_ras) || cpu_stall !== 1'(m_stall) ||
          ref_bank_sel !== BANKS'(m_bsel) || ref_row !== ROW_W'(m_row)) begin
        miscompares++;
        $display("FAIL %s t=%0t ras/stall/bsel/row got %0d/%0d/%h/%0d exp %0d/%0d/%h/%0d",
                 tag, $time, ref_ras, cpu_stall, ref_bank_sel, ref_row,
                 m_ras, m_stall, m_bsel, m_row);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      miscompares++;
      $display("FAIL watchdog expired in phase %s", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(input int rl, input bit s, input bit b, input bit g, input bit h);
    cfg_reload = RELOAD_W'(rl); cfg_slow = s; cfg_burst = b; cfg_stagger = g; cfg_hidden = h;
  endtask

  initial begin
    run(3);
    // R1: outputs quiet during reset
    vectors++;
    if (ref_ras !== 0 || cpu_stall !== 0 || ref_bank_sel !== 0 || ref_row !== 0) begin
      miscompares++;
      $display("FAIL R1 reset outputs got %0d/%0d/%h/%0d exp 0/0/0/0",
               ref_ras, cpu_stall, ref_bank_sel, ref_row);
    end
    rst = 0; checking = 1;
    tag = "R1 R2 R4 R8 R10"; set_mode(20, 0, 0, 0, 0); run(300);
    tag = "R3 R4 R10";       set_mode(10, 1, 0, 0, 0); run(300);
    tag = "R6 R4 R8";        set_mode(20, 0, 1, 0, 0); run(300);
    tag = "R7 R5";           set_mode(8, 0, 0, 1, 0);  run(300);
    tag = "R7 R6";           set_mode(16, 0, 1, 1, 0); run(300);
    tag = "R11";             set_mode(5, 0, 0, 0, 1); ale = 0; run(100);
    tag = "R9 R11";
    for (int i = 0; i < 80; i++) begin ale = 1; run(2); ale = 0; run(2); end
    tag = "R5 R2";           set_mode(4, 0, 0, 0, 0); run(1200);
    tag = "R12";
    for (int i = 0; i < 3000; i++) begin
      cfg_reload  = RELOAD_W'(3 + ($urandom % 8));
      cfg_slow    = 1'($urandom % 4 == 0);
      cfg_burst   = 1'($urandom);
      cfg_stagger = 1'($urandom);
      cfg_hidden  = 1'($urandom % 3 == 0);
      ale         = 1'($urandom);
      run(1);
    end
    checking = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule